// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Timing Monitor

This block is a passive observer for the command bus of a single-data-rate SDRAM. On every rising clock edge it samples chip select, the three command strobes, the clock-enable line and a bank-idle indication from the controller. From these it follows the device through its operating modes (running, self refresh, power-down with all banks closed, power-down with a row open) and keeps cycle counters since the events that open a recovery window. It never drives the memory bus.

When a refresh spacing rule, a low-power entry or exit rule, or the power-down residency limit is broken, the monitor sets a sticky flag for that rule and records the code of the first violation seen. The flags and the code stay set until a synchronous clear. All limits are parameters counted in clock edges. Read and write latency, burst data and row-to-column delays are not examined.

Top module: `sdram_lp_monitor`

## Requirements
- R1: While and after reset, before any command, `err_flags` is 0, `first_code` is 0, `err_any` is 0 and `mode` is 0 (running).
- R2: An auto refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=1, in running mode) sets flag bit 0 unless `banks_idle` was high at that edge and at each of the `T_RP` edges just before it (edges before reset release do not count).
- R3: An activate (cs_n=0, ras_n=0, cas_n=1, we_n=1, cke=1) or another auto refresh at a distance of fewer than `T_RC` edges after an auto refresh edge sets flag bit 1; a distance of exactly `T_RC` is legal.
- R4: The auto refresh pattern with cke=0 in running mode enters self refresh (`mode`=1); if `banks_idle` is low at that edge, flag bit 5 is set.
- R5: An edge with cke=1 in self refresh returns `mode` to 0; any command other than NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) or deselect (cs_n=1) at a distance of fewer than `T_RC`+`T_SREX` edges after that exit edge sets flag bit 2.
- R6: cke=0 in running mode with anything but the auto refresh pattern enters power-down: `mode`=2 if `banks_idle` is high at that edge, otherwise `mode`=3.
- R7: An edge with cke=1 in power-down returns `mode` to 0; if the following edge carries anything other than NOP or deselect, flag bit 3 is set.
- R8: Counting edges after the entry edge that are sampled in power-down with cke=0, flag bit 4 is set at the edge where that count first exceeds `T_PDMAX`.
- R9: In self refresh and power-down, the command pins and `banks_idle` have no effect: only cke changes the mode, and no flag other than bit 4 can be set.
- R10: Flags are sticky; `first_code` takes the value (bit index + 1) of the first violation, the lowest bit index winning when several occur at one edge, and later violations add flags without changing it.
- R11: `clr` high at an edge zeroes `err_flags` and `first_code`; violations at that same edge are discarded, and mode and counters are unaffected.
- R12: `err_any` is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags and code |
| cs_n | input | 1 | Observed chip select, active low |
| ras_n | input | 1 | Observed row strobe, active low |
| cas_n | input | 1 | Observed column strobe, active low |
| we_n | input | 1 | Observed write enable, active low |
| cke | input | 1 | Observed clock enable |
| banks_idle | input | 1 | High when every bank is precharged |
| err_flags | output | 6 | Sticky flag per rule, bit index as in R2 to R8 |
| err_any | output | 1 | OR of all flags |
| first_code | output | 3 | Code of the first violation, 0 when none |
| mode | output | 2 | 0 running, 1 self refresh, 2 power-down idle, 3 power-down with open row |

## Verification
The assertions watch on every cycle the mode transitions driven by cke and the refresh pattern, the stickiness of flags and code, the effect of the clear, the NOP rule on the edge after a power-down exit, and the silence of all other rules while the device sleeps. The window lengths themselves (the idle history before a refresh, the refresh spacing, the self refresh recovery and the residency limit) depend on parameters and are shown only by the bench, which places commands exactly at and one edge inside each limit and checks which flag and code appear.

// File: rtl/sdrmon_pkg.sv
`timescale 1ns/1ps
package sdrmon_pkg;

   typedef enum logic [2:0] {
      CMD_DESEL = 3'd0,
      CMD_NOP   = 3'd1,
      CMD_ACT   = 3'd2,
      CMD_AREF  = 3'd3,
      CMD_OTHER = 3'd4
   } cmd_e;

   typedef enum logic [1:0] {
      MODE_RUN     = 2'd0,
      MODE_SREF    = 2'd1,
      MODE_PD_IDLE = 2'd2,
      MODE_PD_OPEN = 2'd3
   } mode_e;

   localparam int NUM_RULES   = 6;
   localparam int RULE_TRP    = 0;
   localparam int RULE_TRC    = 1;
   localparam int RULE_SRX    = 2;
   localparam int RULE_PDX    = 3;
   localparam int RULE_PDLONG = 4;
   localparam int RULE_SRBUSY = 5;
   localparam int CODE_W      = $clog2(NUM_RULES + 1);

   typedef struct packed {
      cmd_e kind;
      logic quiet;
   } cmd_t;

endpackage

// File: rtl/sdrmon_decode.sv
`timescale 1ns/1ps
module sdrmon_decode
   import sdrmon_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_t cmd
);

   always_comb begin
      cmd.kind = CMD_OTHER;
      if (cs_n) begin
         cmd.kind = CMD_DESEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd.kind = CMD_NOP;
            3'b011:  cmd.kind = CMD_ACT;
            3'b001:  cmd.kind = CMD_AREF;
            default: cmd.kind = CMD_OTHER;
         endcase
      end
      cmd.quiet = (cmd.kind == CMD_DESEL) || (cmd.kind == CMD_NOP);
   end

endmodule

// File: rtl/sdrmon_satcnt.sv
`timescale 1ns/1ps
module sdrmon_satcnt #(
   parameter int W       = 4,
   parameter int SAT     = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         zero,
   input  logic         load_one,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] SAT_V = W'(SAT);
   localparam logic [W-1:0] RST_V = W'(RST_VAL);

   generate
      if (SAT >= (1 << W)) begin : g_bad_width
         $error("sdrmon_satcnt: SAT does not fit in W bits");
      end
      if (RST_VAL > SAT) begin : g_bad_rst
         $error("sdrmon_satcnt: RST_VAL above SAT");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= RST_V;
      end else if (zero) begin
         cnt <= '0;
      end else if (load_one) begin
         cnt <= W'(1);
      end else if (inc && (cnt != SAT_V)) begin
         cnt <= cnt + W'(1);
      end
   end

endmodule

// File: rtl/sdrmon_state.sv
`timescale 1ns/1ps
module sdrmon_state
   import sdrmon_pkg::*;
#(
   parameter int T_RP    = 3,
   parameter int T_RC    = 8,
   parameter int T_SREX  = 2,
   parameter int T_PDMAX = 1000,
   parameter int CNT_W   = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_t             cmd,
   input  logic             cke,
   input  logic             banks_idle,
   output mode_e            mode,
   output logic [CNT_W-1:0] idle_cnt,
   output logic [CNT_W-1:0] rc_cnt,
   output logic [CNT_W-1:0] sx_cnt,
   output logic [CNT_W-1:0] pd_cnt,
   output logic             pdx_pend
);

   localparam int SX_LIM = T_RC + T_SREX;
   localparam int PD_SAT = T_PDMAX + 1;

   logic in_run, in_sref, in_pd;
   logic aref_run, sref_enter, pd_enter, sref_exit, pd_exit;

   always_comb begin
      in_run     = (mode == MODE_RUN);
      in_sref    = (mode == MODE_SREF);
      in_pd      = (mode == MODE_PD_IDLE) || (mode == MODE_PD_OPEN);
      aref_run   = in_run && cke && (cmd.kind == CMD_AREF);
      sref_enter = in_run && !cke && (cmd.kind == CMD_AREF);
      pd_enter   = in_run && !cke && (cmd.kind != CMD_AREF);
      sref_exit  = in_sref && cke;
      pd_exit    = in_pd && cke;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= MODE_RUN;
         pdx_pend <= 1'b0;
      end else begin
         pdx_pend <= pd_exit;
         if (sref_enter) begin
            mode <= MODE_SREF;
         end else if (pd_enter) begin
            mode <= banks_idle ? MODE_PD_IDLE : MODE_PD_OPEN;
         end else if (sref_exit || pd_exit) begin
            mode <= MODE_RUN;
         end
      end
   end

   // consecutive idle edges before the current one
   sdrmon_satcnt #(.W(CNT_W), .SAT(T_RP), .RST_VAL(0)) u_idle (
      .clk(clk), .rst_n(rst_n),
      .zero(!banks_idle), .load_one(1'b0), .inc(1'b1),
      .cnt(idle_cnt)
   );

   // distance from the last awake refresh
   sdrmon_satcnt #(.W(CNT_W), .SAT(T_RC), .RST_VAL(T_RC)) u_rc (
      .clk(clk), .rst_n(rst_n),
      .zero(1'b0), .load_one(aref_run), .inc(1'b1),
      .cnt(rc_cnt)
   );

   // distance from the last self refresh exit
   sdrmon_satcnt #(.W(CNT_W), .SAT(SX_LIM), .RST_VAL(SX_LIM)) u_sx (
      .clk(clk), .rst_n(rst_n),
      .zero(1'b0), .load_one(sref_exit), .inc(1'b1),
      .cnt(sx_cnt)
   );

   // edges spent asleep in power-down
   sdrmon_satcnt #(.W(CNT_W), .SAT(PD_SAT), .RST_VAL(0)) u_pd (
      .clk(clk), .rst_n(rst_n),
      .zero(pd_enter), .load_one(1'b0), .inc(in_pd && !cke),
      .cnt(pd_cnt)
   );

endmodule

// File: rtl/sdrmon_rules.sv
`timescale 1ns/1ps
module sdrmon_rules
   import sdrmon_pkg::*;
#(
   parameter int T_RP    = 3,
   parameter int T_RC    = 8,
   parameter int T_SREX  = 2,
   parameter int T_PDMAX = 1000,
   parameter int CNT_W   = 11
) (
   input  cmd_t                 cmd,
   input  logic                 cke,
   input  logic                 banks_idle,
   input  mode_e                mode,
   input  logic [CNT_W-1:0]     idle_cnt,
   input  logic [CNT_W-1:0]     rc_cnt,
   input  logic [CNT_W-1:0]     sx_cnt,
   input  logic [CNT_W-1:0]     pd_cnt,
   input  logic                 pdx_pend,
   output logic [NUM_RULES-1:0] viol
);

   localparam logic [CNT_W-1:0] RP_V    = CNT_W'(T_RP);
   localparam logic [CNT_W-1:0] RC_V    = CNT_W'(T_RC);
   localparam logic [CNT_W-1:0] SX_V    = CNT_W'(T_RC + T_SREX);
   localparam logic [CNT_W-1:0] PDMAX_V = CNT_W'(T_PDMAX);

   logic in_run, in_pd, awake_aref, awake_act;

   always_comb begin
      in_run     = (mode == MODE_RUN);
      in_pd      = (mode == MODE_PD_IDLE) || (mode == MODE_PD_OPEN);
      awake_aref = in_run && cke && (cmd.kind == CMD_AREF);
      awake_act  = in_run && cke && (cmd.kind == CMD_ACT);

      viol              = '0;
      viol[RULE_TRP]    = awake_aref && (!banks_idle || (idle_cnt < RP_V));
      viol[RULE_TRC]    = (awake_aref || awake_act) && (rc_cnt < RC_V);
      viol[RULE_SRX]    = in_run && !cmd.quiet && (sx_cnt < SX_V);
      viol[RULE_PDX]    = in_run && pdx_pend && !cmd.quiet;
      viol[RULE_PDLONG] = in_pd && !cke && (pd_cnt == PDMAX_V);
      viol[RULE_SRBUSY] = in_run && !cke && (cmd.kind == CMD_AREF) && !banks_idle;
   end

endmodule

// File: rtl/sdrmon_errlog.sv
`timescale 1ns/1ps
module sdrmon_errlog
   import sdrmon_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [NUM_RULES-1:0] viol,
   output logic [NUM_RULES-1:0] flags,
   output logic [CODE_W-1:0]    code
);

   logic [CODE_W-1:0] pick;

   generate
      for (genvar i = 0; i < NUM_RULES; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags[i] <= 1'b0;
            end else if (clr) begin
               flags[i] <= 1'b0;
            end else if (viol[i]) begin
               flags[i] <= 1'b1;
            end
         end
      end
   endgenerate

   // lowest index wins
   always_comb begin
      pick = '0;
      for (int i = NUM_RULES - 1; i >= 0; i--) begin
         if (viol[i]) pick = CODE_W'(i + 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
      end else if (clr) begin
         code <= '0;
      end else if ((code == '0) && (pick != '0)) begin
         code <= pick;
      end
   end

endmodule

// File: rtl/sdram_lp_monitor.sv
`timescale 1ns/1ps
module sdram_lp_monitor
   import sdrmon_pkg::*;
#(
   parameter int T_RP    = 3,
   parameter int T_RC    = 8,
   parameter int T_SREX  = 2,
   parameter int T_PDMAX = 1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic                 cke,
   input  logic                 banks_idle,
   output logic [NUM_RULES-1:0] err_flags,
   output logic                 err_any,
   output logic [CODE_W-1:0]    first_code,
   output logic [1:0]           mode
);

   localparam int MAX_A = (T_RC + T_SREX > T_RP) ? (T_RC + T_SREX) : T_RP;
   localparam int MAX_L = (T_PDMAX + 1 > MAX_A) ? (T_PDMAX + 1) : MAX_A;
   localparam int CNT_W = $clog2(MAX_L + 1) + 1;

   generate
      if (T_RP < 1)    begin : g_chk_rp  $error("T_RP must be at least 1");    end
      if (T_RC < 1)    begin : g_chk_rc  $error("T_RC must be at least 1");    end
      if (T_SREX < 0)  begin : g_chk_sx  $error("T_SREX must not be negative"); end
      if (T_PDMAX < 1) begin : g_chk_pd  $error("T_PDMAX must be at least 1"); end
   endgenerate

   cmd_t                 cmd;
   mode_e                mode_q;
   logic [CNT_W-1:0]     idle_cnt, rc_cnt, sx_cnt, pd_cnt;
   logic                 pdx_pend;
   logic [NUM_RULES-1:0] viol;

   sdrmon_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .cmd(cmd)
   );

   sdrmon_state #(
      .T_RP(T_RP), .T_RC(T_RC), .T_SREX(T_SREX), .T_PDMAX(T_PDMAX), .CNT_W(CNT_W)
   ) u_state (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .cke(cke), .banks_idle(banks_idle),
      .mode(mode_q), .idle_cnt(idle_cnt), .rc_cnt(rc_cnt), .sx_cnt(sx_cnt),
      .pd_cnt(pd_cnt), .pdx_pend(pdx_pend)
   );

   sdrmon_rules #(
      .T_RP(T_RP), .T_RC(T_RC), .T_SREX(T_SREX), .T_PDMAX(T_PDMAX), .CNT_W(CNT_W)
   ) u_rules (
      .cmd(cmd), .cke(cke), .banks_idle(banks_idle), .mode(mode_q),
      .idle_cnt(idle_cnt), .rc_cnt(rc_cnt), .sx_cnt(sx_cnt), .pd_cnt(pd_cnt),
      .pdx_pend(pdx_pend), .viol(viol)
   );

   sdrmon_errlog u_log (
      .clk(clk), .rst_n(rst_n), .clr(clr), .viol(viol),
      .flags(err_flags), .code(first_code)
   );

   assign err_any = |err_flags;
   assign mode    = mode_q;

endmodule

// File: rtl/sdrmon_chk.sv
`timescale 1ns/1ps
module sdrmon_chk
   import sdrmon_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clr,
   input logic                 cs_n,
   input logic                 ras_n,
   input logic                 cas_n,
   input logic                 we_n,
   input logic                 cke,
   input logic                 banks_idle,
   input logic [NUM_RULES-1:0] err_flags,
   input logic                 err_any,
   input logic [CODE_W-1:0]    first_code,
   input logic [1:0]           mode
);

   logic pat_ref, pat_quiet, asleep_pd;
   assign pat_ref   = !cs_n && !ras_n && !cas_n && we_n;
   assign pat_quiet = cs_n || (ras_n && cas_n && we_n);
   assign asleep_pd = (mode == MODE_PD_IDLE) || (mode == MODE_PD_OPEN);

   a_r11_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (err_flags == '0) && (first_code == '0));

   a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

   a_r10_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (first_code != '0)) |=> (first_code == $past(first_code)));

   a_r12_any_vs_code: assert property (@(posedge clk) disable iff (!rst_n)
      err_any == (first_code != '0));

   a_r4_sref_enter: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_RUN) && !cke && pat_ref) |=> (mode == MODE_SREF));

   a_r9_sref_stays: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_SREF) && !cke) |=> (mode == MODE_SREF));

   a_r5_sref_leave: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_SREF) && cke) |=> (mode == MODE_RUN));

   a_r6_pd_enter: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_RUN) && !cke && !pat_ref) |=>
         (mode == ($past(banks_idle) ? MODE_PD_IDLE : MODE_PD_OPEN)));

   a_r7_pd_leave: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep_pd && cke) |=> (mode == MODE_RUN));

   a_r7_exit_needs_nop: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep_pd && cke && !clr) ##1 (!clr && !pat_quiet) |=> err_flags[RULE_PDX]);

   a_r9_sleep_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (((mode == MODE_SREF) || (asleep_pd && !cke)) && !clr) |=>
         ((err_flags | (NUM_RULES'(1) << RULE_PDLONG)) ==
          ($past(err_flags) | (NUM_RULES'(1) << RULE_PDLONG))));

endmodule

bind sdram_lp_monitor sdrmon_chk u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr),
   .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
   .cke(cke), .banks_idle(banks_idle),
   .err_flags(err_flags), .err_any(err_any), .first_code(first_code), .mode(mode)
);

// File: tb/sdram_lp_monitor_test.sv
`timescale 1ns/1ps
module sdram_lp_monitor_test;

   localparam int T_RP = 3, T_RC = 5, T_SREX = 2, T_PDMAX = 6;
   localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_REF = 4'b0001;

   logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
   logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic cke = 1'b1, banks_idle = 1'b1;
   logic [5:0] err_flags;
   logic       err_any;
   logic [2:0] first_code;
   logic [1:0] mode;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [5:0] exp_flags = '0;
   logic [2:0] exp_code  = '0;
   logic [1:0] exp_mode  = '0;

   typedef struct {
      logic [5:0] flags;
      logic [2:0] code;
      logic [1:0] mode;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   sdram_lp_monitor #(.T_RP(T_RP), .T_RC(T_RC), .T_SREX(T_SREX), .T_PDMAX(T_PDMAX)) uut (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .cke(cke), .banks_idle(banks_idle),
      .err_flags(err_flags), .err_any(err_any), .first_code(first_code), .mode(mode)
   );

   task automatic compare(input logic [5:0] f, input logic [2:0] c, input logic [1:0] m,
                          input string tag);
      checks++;
      if (err_flags !== f || first_code !== c || mode !== m || err_any !== (f != 0)) begin
         fails++;
         $display("FAIL %s: flags=%b code=%0d mode=%0d any=%b expected flags=%b code=%0d mode=%0d any=%b",
                  tag, err_flags, first_code, mode, err_any, f, c, m, (f != 0));
      end
   endtask

   // driver: applies one edge of stimulus and queues the state expected after it
   task automatic drive(input logic [3:0] pins, input logic k, input logic id,
                        input logic c, input string tag);
      exp_t e;
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = pins;
      cke = k; banks_idle = id; clr = c;
      e.flags = exp_flags; e.code = exp_code; e.mode = exp_mode; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic nops(input int n, input logic k, input logic id, input string tag);
      for (int i = 0; i < n; i++) drive(P_NOP, k, id, 1'b0, tag);
   endtask

   task automatic clear(input string tag);
      exp_flags = '0; exp_code = '0;
      drive(P_NOP, 1'b1, 1'b1, 1'b1, tag);
   endtask

   // monitor: compares a quarter period after the edge that consumed the item
   initial begin
      forever begin
         exp_t e;
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            e = q.pop_front();
            compare(e.flags, e.code, e.mode, e.tag);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare('0, '0, '0, "R1 during reset");
      rst_n = 1'b1;
      nops(5, 1'b1, 1'b1, "R1 reset state");

      // R3: refresh then activate exactly T_RC edges later is legal
      drive(P_REF, 1'b1, 1'b1, 1'b0, "R2 refresh after idle history");
      nops(4, 1'b1, 1'b1, "R3 spacing gap");
      drive(P_ACT, 1'b1, 1'b1, 1'b0, "R3 activate at T_RC");
      nops(5, 1'b1, 1'b1, "R3 settle");
      drive(P_REF, 1'b1, 1'b1, 1'b0, "R3 first refresh");
      nops(1, 1'b1, 1'b1, "R3 gap");
      exp_flags = 6'b000010; exp_code = 3'd2;
      drive(P_REF, 1'b1, 1'b1, 1'b0, "R3 refresh too close");

      // R11: clear, and a violation on a clear edge is dropped
      clear("R11 clear");
      drive(P_REF, 1'b1, 1'b1, 1'b1, "R11 violation on clear edge dropped");

      // R2: short idle history
      nops(1, 1'b1, 1'b1, "R2 prep");
      nops(1, 1'b1, 1'b0, "R2 banks busy");
      nops(2, 1'b1, 1'b1, "R2 idle two edges");
      exp_flags = 6'b000001; exp_code = 3'd1;
      drive(P_REF, 1'b1, 1'b1, 1'b0, "R2 refresh with short idle history");
      exp_flags = 6'b000011;
      drive(P_ACT, 1'b1, 1'b1, 1'b0, "R10 later violation keeps code");
      clear("R11 clear again");
      exp_flags = 6'b000011; exp_code = 3'd1;
      drive(P_REF, 1'b1, 1'b0, 1'b0, "R10 same-edge priority");
      clear("R11 clear");
      nops(6, 1'b1, 1'b1, "settle");

      // R4/R5/R9: self refresh
      exp_mode = 2'd1;
      drive(P_REF, 1'b0, 1'b1, 1'b0, "R4 self refresh entry");
      for (int i = 0; i < 3; i++) drive(P_ACT, 1'b0, 1'b0, 1'b0, "R9 pins ignored in self refresh");
      exp_mode = 2'd0;
      drive(P_NOP, 1'b1, 1'b1, 1'b0, "R5 self refresh exit");
      nops(6, 1'b1, 1'b1, "R5 recovery");
      drive(P_ACT, 1'b1, 1'b1, 1'b0, "R5 activate at recovery limit");
      nops(2, 1'b1, 1'b1, "settle");
      exp_mode = 2'd1;
      drive(P_REF, 1'b0, 1'b1, 1'b0, "R4 entry again");
      exp_mode = 2'd0;
      drive(P_NOP, 1'b1, 1'b1, 1'b0, "R5 exit again");
      nops(5, 1'b1, 1'b1, "R5 recovery");
      exp_flags = 6'b000100; exp_code = 3'd3;
      drive(P_ACT, 1'b1, 1'b1, 1'b0, "R5 activate inside recovery");
      nops(2, 1'b1, 1'b1, "settle");
      clear("R11 clear");
      exp_flags = 6'b100000; exp_code = 3'd6; exp_mode = 2'd1;
      drive(P_REF, 1'b0, 1'b0, 1'b0, "R4 entry with busy banks");
      exp_mode = 2'd0;
      drive(P_NOP, 1'b1, 1'b1, 1'b0, "R5 exit");
      nops(8, 1'b1, 1'b1, "settle");

      // R6/R7/R8/R9: power-down
      clear("R11 clear");
      exp_mode = 2'd2;
      drive(P_NOP, 1'b0, 1'b1, 1'b0, "R6 power-down entry idle");
      for (int i = 0; i < 6; i++) drive(P_REF, 1'b0, 1'b0, 1'b0, "R9 pins ignored in power-down");
      exp_mode = 2'd0;
      drive(P_NOP, 1'b1, 1'b1, 1'b0, "R7 exit at residency limit");
      nops(1, 1'b1, 1'b1, "R7 nop after exit");
      exp_mode = 2'd3;
      drive(P_NOP, 1'b0, 1'b0, 1'b0, "R6 power-down entry open row");
      exp_mode = 2'd0;
      drive(P_ACT, 1'b1, 1'b1, 1'b0, "R7 exit edge pins ignored");
      exp_flags = 6'b001000; exp_code = 3'd4;
      drive(P_ACT, 1'b1, 1'b1, 1'b0, "R7 command right after exit");
      nops(1, 1'b1, 1'b1, "settle");
      clear("R11 clear");
      exp_mode = 2'd2;
      drive(P_NOP, 1'b0, 1'b1, 1'b0, "R6 entry");
      nops(6, 1'b0, 1'b1, "R8 within limit");
      exp_flags = 6'b010000; exp_code = 3'd5;
      nops(1, 1'b0, 1'b1, "R8 residency exceeded");
      nops(2, 1'b0, 1'b1, "R8 stays flagged");
      exp_mode = 2'd0;
      drive(P_NOP, 1'b1, 1'b1, 1'b0, "R7 exit");
      nops(2, 1'b1, 1'b1, "R12 final");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule